// File: doc/BRIEF.md
# Repeater Link Mode Controller

This block is the control state machine of a two-channel serial link repeater. It decides when each channel's receiver termination is presented, when each transmitter drives, and when far-end receiver detection is requested. The analog termination, driver and detect circuits are not part of it. They appear as digital controls, plus a per-channel request/response pair that connects to an abstract detect unit.

An active-low mode-reset input holds the block in sleep. In sleep every input termination is high impedance and every transmitter is off. When that input rises, the detect-enable strap is sampled once. With the strap high, the block issues detect requests on a fixed period. A channel that reports a far-end termination keeps its termination presented and is not asked again. Once every channel has reported a termination, the block enters active operation. With the strap low, detection is skipped and the block goes straight to active.

Top module: `repeater_link_ctrl`

## Requirements
- R1: After the power-on reset `rst_n`, and whenever the synchronised `mode_rst_n` is low, `mode_o` is 0 (sleep), `term_hiz` is all ones, `tx_oe` is all zeros and `det_req` is all zeros.
- R2: The state changes on the third rising clock edge after a `mode_rst_n` low-to-high transition. If `det_en` is 0 at that point, `mode_o` becomes 2 (active), `term_hiz` becomes all zeros and `tx_oe` becomes all ones.
- R3: If `det_en` is 1 at the synchronised rising edge, `mode_o` becomes 1 (detect), and `det_req` pulses for every channel in that first detect cycle, well within `WAKE_MAX` cycles of the release.
- R4: In detect, each `det_req` pulse lasts one cycle. When responses arrive sooner than the period, the pulses repeat every `DET_PERIOD` cycles, and they repeat indefinitely while no termination is found.
- R5: `cable_disc` is 1 exactly while the block is in detect and no channel has found a far-end termination.
- R6: A `det_valid[i]` response with `det_found[i]`=1 to an outstanding request sets channel i as found. That channel's `term_hiz[i]` goes to 0, it receives no further requests, and the block stays in detect while another channel is unfound.
- R7: When every channel is found, the block moves to active (`mode_o`=2), with `tx_oe` all ones and `term_hiz` all zeros.
- R8: Driving `mode_rst_n` low from detect or active returns the block to sleep within 3 cycles, and always within `SLEEP_MAX` cycles.
- R9: After the release edge, changes of `det_en` have no effect on the state.
- R10: A `det_valid[i]` arriving while channel i has no outstanding request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| mode_rst_n | input | 1 | Asynchronous active-low mode reset (sleep while low) |
| det_en | input | 1 | Detect-enable strap, sampled at the mode-reset rising edge |
| det_valid | input | NCH | Per-channel detect response strobe |
| det_found | input | NCH | Per-channel far-end termination result, valid with det_valid |
| det_req | output | NCH | Per-channel one-cycle detect request |
| term_hiz | output | NCH | 1 = input termination high impedance, 0 = nominal |
| tx_oe | output | NCH | 1 = transmitter driving, 0 = high-Z |
| cable_disc | output | 1 | Detect state with no far end found on any channel |
| mode_o | output | 2 | 0 sleep, 1 detect, 2 active |

## Verification
The hardest situation to reach from the ports is a detect response that arrives while no request is outstanding. A correct detect unit never produces one. The bench therefore adds a separate injection path, ORed onto the responder's strobe, and fires it in the idle gap between two periodic requests. It then confirms at the ports that termination and disconnect status are unchanged. A second hard case is a split result, where only one channel finds a far end. The bench holds that case for several detect periods, confirms that the found channel receives no further requests, and then adds the missing far end to trigger the move to active.

// File: rtl/repeater_link_pkg.sv
package repeater_link_pkg;
  typedef enum logic [1:0] {
    LM_SLEEP  = 2'd0,
    LM_DETECT = 2'd1,
    LM_ACTIVE = 2'd2
  } link_mode_e;
endpackage

// File: rtl/rlc_sync.sv
module rlc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rlc_det_sched.sv
module rlc_det_sched #(
  parameter int NCH        = 2,
  parameter int DET_PERIOD = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [NCH-1:0] rsp_valid,
  input  logic [NCH-1:0] rsp_found,
  output logic [NCH-1:0] req,
  output logic [NCH-1:0] found
);
  localparam int CW = $clog2(DET_PERIOD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(DET_PERIOD - 1);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] found_q;
  logic           fire;

  assign fire = run && (cnt_q == '0) && (pend_q == '0);
  assign req  = fire ? ~found_q : '0;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = '0;
    else if (fire)           cnt_d = RELOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic pend_d, found_d;

    always_comb begin
      pend_d  = pend_q[g];
      found_d = found_q[g];
      if (!run) begin
        pend_d  = 1'b0;
        found_d = 1'b0;
      end else begin
        if (req[g])                      pend_d = 1'b1;
        else if (rsp_valid[g])           pend_d = 1'b0;
        if (pend_q[g] && rsp_valid[g] && rsp_found[g]) found_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g]  <= 1'b0;
        found_q[g] <= 1'b0;
      end else begin
        pend_q[g]  <= pend_d;
        found_q[g] <= found_d;
      end
    end
  end

  assign found = found_q;
endmodule

// File: rtl/repeater_link_ctrl.sv
module repeater_link_ctrl
  import repeater_link_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int DET_PERIOD = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_rst_n,
  input  logic           det_en,
  input  logic [NCH-1:0] det_valid,
  input  logic [NCH-1:0] det_found,
  output logic [NCH-1:0] det_req,
  output logic [NCH-1:0] term_hiz,
  output logic [NCH-1:0] tx_oe,
  output logic           cable_disc,
  output logic [1:0]     mode_o
);
  logic       rst_int_n;
  logic       mrst_s;
  logic       mrst_prev_q;
  logic       mrst_rise;
  link_mode_e st_q, st_d;
  logic [NCH-1:0] found;

  rlc_sync #(.STAGES(SYNC_STG)) u_por_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  rlc_sync #(.STAGES(SYNC_STG)) u_mrst_sync (
    .clk(clk), .arst_n(rst_int_n), .d(mode_rst_n), .q(mrst_s)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mrst_prev_q <= 1'b0;
    else            mrst_prev_q <= mrst_s;
  end

  assign mrst_rise = mrst_s && !mrst_prev_q;

  rlc_det_sched #(.NCH(NCH), .DET_PERIOD(DET_PERIOD)) u_sched (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (st_q == LM_DETECT),
    .rsp_valid (det_valid),
    .rsp_found (det_found),
    .req       (det_req),
    .found     (found)
  );

  always_comb begin
    st_d = st_q;
    if (!mrst_s) begin
      st_d = LM_SLEEP;
    end else begin
      case (st_q)
        LM_SLEEP:  if (mrst_rise) st_d = det_en ? LM_DETECT : LM_ACTIVE;
        LM_DETECT: if (&found)    st_d = LM_ACTIVE;
        LM_ACTIVE: st_d = LM_ACTIVE;
        default:   st_d = LM_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= LM_SLEEP;
    else            st_q <= st_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign term_hiz[g] = (st_q == LM_SLEEP) || ((st_q == LM_DETECT) && !found[g]);
    assign tx_oe[g]    = (st_q == LM_ACTIVE);
  end

  assign cable_disc = (st_q == LM_DETECT) && (found == '0);
  assign mode_o     = st_q;
endmodule

// File: rtl/repeater_link_chk.sv
module repeater_link_chk #(
  parameter int NCH       = 2,
  parameter int WAKE_MAX  = 500,
  parameter int SLEEP_MAX = 50
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mode_rst_n,
  input logic [NCH-1:0] det_req,
  input logic [NCH-1:0] term_hiz,
  input logic [NCH-1:0] tx_oe,
  input logic           cable_disc,
  input logic [1:0]     mode_o
);
  int unsigned low_cnt;
  int unsigned wake_cnt;
  logic        woke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= 0;
      wake_cnt <= 0;
      woke_q   <= 1'b0;
    end else begin
      if (mode_rst_n) low_cnt <= 0;
      else if (low_cnt < SLEEP_MAX) low_cnt <= low_cnt + 1;
      if (!mode_rst_n) begin
        wake_cnt <= 0;
        woke_q   <= 1'b0;
      end else if ((|det_req) || mode_o == 2'd2) begin
        woke_q   <= 1'b1;
      end else if (!woke_q && wake_cnt < WAKE_MAX) begin
        wake_cnt <= wake_cnt + 1;
      end
    end
  end

  AST_SLEEP_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (&term_hiz && tx_oe == '0 && det_req == '0)); // R1
  AST_REQ_IN_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (|det_req) |-> (mode_o == 2'd1)); // R3
  AST_WAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cnt < WAKE_MAX)); // R3
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|det_req) |=> !(|det_req)); // R4
  AST_DISC_MEANS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    cable_disc |-> (mode_o == 2'd1 && &term_hiz)); // R5
  AST_TX_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_oe) |-> (mode_o == 2'd2)); // R7
  AST_ACTIVE_FROM_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && $past(mode_o) == 2'd1) |-> ($past(term_hiz) == '0)); // R7
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt >= SLEEP_MAX) |-> (mode_o == 2'd0)); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd3)); // R1
endmodule

bind repeater_link_ctrl repeater_link_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_rst_n (mode_rst_n),
  .det_req    (det_req),
  .term_hiz   (term_hiz),
  .tx_oe      (tx_oe),
  .cable_disc (cable_disc),
  .mode_o     (mode_o)
);

// File: tb/sim_repeater_link_ctrl.sv
`timescale 1ns/1ps
module sim_repeater_link_ctrl;
  localparam int NCH = 2;
  localparam int PER = 16;
  localparam int LAT = 3;

  logic           clk = 1'b0;
  logic           rst_n, mode_rst_n, det_en;
  logic [NCH-1:0] rsp_v, rsp_f, inj_v, inj_f, far;
  logic [NCH-1:0] det_valid, det_found, det_req, term_hiz, tx_oe;
  logic           cable_disc;
  logic [1:0]     mode_o;
  int             checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign det_valid = rsp_v | inj_v;
  assign det_found = rsp_f | inj_f;

  repeater_link_ctrl #(.NCH(NCH), .DET_PERIOD(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_rst_n(mode_rst_n), .det_en(det_en),
    .det_valid(det_valid), .det_found(det_found), .det_req(det_req),
    .term_hiz(term_hiz), .tx_oe(tx_oe), .cable_disc(cable_disc), .mode_o(mode_o)
  );

  // detect unit model: answers each request after LAT cycles
  initial begin
    int cd [NCH];
    rsp_v = '0; rsp_f = '0;
    for (int c = 0; c < NCH; c++) cd[c] = 0;
    forever begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        rsp_v[c] = 1'b0; rsp_f[c] = 1'b0;
        if (cd[c] != 0) begin
          cd[c]--;
          if (cd[c] == 0) begin rsp_v[c] = 1'b1; rsp_f[c] = far[c]; end
        end
        if (det_req[c]) cd[c] = LAT;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode(input bit strap, input logic [NCH-1:0] f);
    if (!strap) return 2;
    return (&f) ? 2 : 1;
  endfunction

  function automatic int exp_term(input bit strap, input logic [NCH-1:0] f);
    if (exp_mode(strap, f) == 2) return 0;
    return int'(~f) & ((1 << NCH) - 1);
  endfunction

  task automatic restart(input bit strap, input logic [NCH-1:0] f);
    mode_rst_n = 1'b0;
    cyc(6);
    det_en = strap; far = f;
    cyc(1);
    mode_rst_n = 1'b1;
    cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [NCH-1:0] seen;
    void'($urandom(32'h1A2B));
    rst_n = 1'b0; mode_rst_n = 1'b0; det_en = 1'b1; far = '0;
    inj_v = '0; inj_f = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(6);
    // R1 reset / sleep state
    chk(mode_o == 2'd0, "R1 mode", mode_o, 0);
    chk(term_hiz == 2'b11 && tx_oe == 2'b00 && det_req == 2'b00, "R1 outputs",
        {term_hiz, tx_oe, det_req}, 6'b110000);

    // R2 strap low -> active after three edges
    det_en = 1'b0; cyc(1); mode_rst_n = 1'b1; cyc(2);
    chk(mode_o == 2'd0, "R2 not before third edge", mode_o, 0);
    cyc(1);
    chk(mode_o == 2'd2, "R2 mode", mode_o, 2);
    chk(term_hiz == 2'b00 && tx_oe == 2'b11, "R2 outputs", {term_hiz, tx_oe}, 4'b0011);
    // R9 strap change ignored while active
    det_en = 1'b1; cyc(20);
    chk(mode_o == 2'd2, "R9 strap ignored", mode_o, 2);
    // R8 sleep entry from active
    mode_rst_n = 1'b0; cyc(3);
    chk(mode_o == 2'd0 && term_hiz == 2'b11 && tx_oe == 2'b00, "R8 sleep from active",
        mode_o, 0);

    // R3 detect entry with request in first cycle
    restart(1'b1, 2'b00);
    chk(mode_o == 2'd1, "R3 mode", mode_o, 1);
    chk(det_req == 2'b11, "R3 first request", det_req, 3);
    chk(cable_disc == 1'b1, "R5 disconnect none found", cable_disc, 1);
    // R4 periodic requests; R10 injection in idle gap at offset 8
    n = 0;
    for (int k = 0; k < 10 * PER; k++) begin
      if (det_req[0]) n++;
      inj_v = (k == 8) ? 2'b01 : 2'b00;
      inj_f = (k == 8) ? 2'b01 : 2'b00;
      cyc(1);
    end
    inj_v = '0; inj_f = '0;
    chk(n == 10, "R4 request count", n, 10);
    chk(term_hiz == 2'b11 && cable_disc == 1'b1, "R10 unsolicited response ignored",
        {term_hiz, cable_disc}, 3'b111);
    // R9 strap change ignored while detecting
    det_en = 1'b0; cyc(20);
    chk(mode_o == 2'd1, "R9 strap ignored in detect", mode_o, 1);
    // R8 sleep entry from detect
    mode_rst_n = 1'b0; cyc(3);
    chk(mode_o == 2'd0 && det_req == 2'b00, "R8 sleep from detect", mode_o, 0);

    // R6 one channel found
    restart(1'b1, 2'b01);
    cyc(LAT + 4);
    seen = '0;
    for (int k = 0; k < 3 * PER; k++) begin seen |= det_req; cyc(1); end
    chk(mode_o == 2'd1, "R6 stays in detect", mode_o, 1);
    chk(term_hiz == 2'b10, "R6 found channel termination", term_hiz, 2);
    chk(seen == 2'b10, "R6 found channel not re-requested", seen, 2);
    chk(cable_disc == 1'b0, "R5 disconnect clears", cable_disc, 0);
    // R7 second far end appears
    far = 2'b11;
    cyc(PER + LAT + 4);
    chk(mode_o == 2'd2, "R7 mode", mode_o, 2);
    chk(tx_oe == 2'b11 && term_hiz == 2'b00, "R7 outputs", {tx_oe, term_hiz}, 4'b1100);

    // random trials
    for (int t = 0; t < 24; t++) begin
      bit strap;
      logic [NCH-1:0] f;
      strap = 1'($urandom);
      f     = NCH'($urandom);
      restart(strap, f);
      cyc(PER * 3);
      chk(int'(mode_o) == exp_mode(strap, f), "R2 R3 R7 random mode", mode_o,
          exp_mode(strap, f));
      chk(int'(term_hiz) == exp_term(strap, f), "R6 random termination", term_hiz,
          exp_term(strap, f));
      chk(cable_disc == (strap && f == '0), "R5 random disconnect", cable_disc,
          int'(strap && f == '0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule